// File: doc/BRIEF.md
# Feedthrough SEC-DED Bus Error Corrector

This block sits on the data path between a processor and a protected memory. The processor side carries a 17-bit word: 16 data bits, with a parity bit in position 16. The memory side carries the same 17 bits and 6 check bits, 23 bits in all. The block is purely combinational.

In a write cycle the block passes the processor word to the memory bus and computes the check bits beside it. In a read cycle it recomputes the check bits from the memory word and compares them with the stored ones. It corrects any single flipped bit, detects any two flipped bits, and reports both through active-low flags.

Three select inputs gate every output driver: two are active low and one is active high. A correction-enable input can bypass the repair, so that the raw memory word is visible. A flag-enable input can silence the two flags. An active-low external error input is merged into the uncorrectable flag. Each tri-state bus is modelled as separate in, out and output-enable ports.

Top module: `edac_feedthrough`

## Requirements
- R1: In a selected write cycle (`rd_wr_n`=0), `md_out` equals `pd_in`, `cb_out` carries the check bits of `pd_in`, `md_oe`=1 and `pd_oe`=0.
- R2: In a selected read cycle (`rd_wr_n`=1) with no error, `pd_out` equals `md_in`, `pd_oe`=1, `md_oe`=0, and both flags are high.
- R3: A single flipped bit in any of the 17 word bits (parity bit 16 included) is corrected on `pd_out`, with `cerr_n`=0 and `ncerr_n`=1.
- R4: A single flipped check bit leaves `pd_out` equal to the stored word, with `cerr_n`=0 and `ncerr_n`=1.
- R5: Any two flipped bits among the 23 give `ncerr_n`=0 and `cerr_n`=1, and the word is not altered.
- R6: With `corr_en`=0, `pd_out` equals `md_in` unmodified even when an error is present, and the flags still report it.
- R7: With `flag_en`=0, `cerr_n` is high, and `ncerr_n` is high unless `ext_err_n` is low.
- R8: `ext_err_n`=0 drives `ncerr_n` low regardless of flag enable, cycle direction or selects.
- R9: The block is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. Otherwise both output enables are 0 and both flags are high, apart from the case in R8.
- R10: Decode flags report only in a selected read cycle. In a write cycle a corrupt `md_in` leaves both flags high.
- R11: The code gives word bit i a 6-bit column. Columns are the weight-3 six-bit values in ascending order, so bit 0 gets 0x07 and bit 16 gets 0x31. Check bit k is the XOR of the word bits whose column has bit k set. Check bit k on its own has column 1<<k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pd_in | input | 17 | Processor bus value received (data plus parity in bit 16) |
| pd_out | output | 17 | Value driven onto the processor bus |
| pd_oe | output | 1 | Processor bus driver enable |
| md_in | input | 17 | Memory word received |
| md_out | output | 17 | Memory word driven |
| cb_in | input | 6 | Stored check bits received |
| cb_out | output | 6 | Generated check bits driven |
| md_oe | output | 1 | Memory word and check-bit driver enable |
| rd_wr_n | input | 1 | 1 selects read (memory to processor), 0 selects write |
| sel_a_n | input | 1 | Active-low select |
| sel_b_n | input | 1 | Active-low select |
| sel_c | input | 1 | Active-high select |
| corr_en | input | 1 | 1 drives corrected data, 0 drives raw memory data |
| flag_en | input | 1 | 1 lets decode results reach the flags |
| ext_err_n | input | 1 | Active-low external error, merged into ncerr_n |
| cerr_n | output | 1 | Active-low correctable-error flag |
| ncerr_n | output | 1 | Active-low uncorrectable-error flag |

## Verification
The assertions are checked continuously whenever an input changes. They cover these relations:
- The two drivers are never enabled together.
- A zero syndrome never alters the word.
- Bypass always yields the raw memory word.
- A write always mirrors the processor word.
- Flag masking and the external error merge hold.
- Both flags never show a decode result at once.

Only the bench's scenarios can show the code itself is right. That means:
- the exact check-bit values;
- that each chosen single-bit position is repaired;
- that double errors among word and check bits are detected rather than miscorrected;
- that reads, writes and deselection produce the expected outputs.

// File: rtl/edac_pkg.sv
// Package: shared widths and the constant functions that define the
// odd-column-weight code. Assumes CHK_W is large enough that there are at
// least WORD_W weight-3 columns.
package edac_pkg;

    localparam int DATA_W = 16;
    localparam int WORD_W = DATA_W + 1;
    localparam int CHK_W  = 6;
    localparam int COL_WEIGHT = 3;

    // Count set bits of a column value.
    function automatic int col_pop(input logic [CHK_W-1:0] v);
        int n;
        n = 0;
        for (int b = 0; b < CHK_W; b++) begin
            n = n + int'(v[b]);
        end
        return n;
    endfunction

    // Column of word bit idx: idx-th weight-3 value in ascending order.
    function automatic logic [CHK_W-1:0] word_col(input int idx);
        int seen;
        logic [CHK_W-1:0] res;
        seen = 0;
        res  = '0;
        for (int v = 0; v < (1 << CHK_W); v++) begin
            if (col_pop(CHK_W'(v)) == COL_WEIGHT) begin
                if (seen == idx) begin
                    res = CHK_W'(v);
                end
                seen = seen + 1;
            end
        end
        return res;
    endfunction

    // Mask of word bits that feed check bit k.
    function automatic logic [WORD_W-1:0] row_mask(input int k);
        logic [WORD_W-1:0] m;
        logic [CHK_W-1:0]  c;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            c    = word_col(i);
            m[i] = c[k];
        end
        return m;
    endfunction

endpackage

// File: rtl/edac_encoder.sv
// Module: check-bit generator. Each check bit is the parity of the word
// bits selected by its row of the code matrix. Purely combinational.
module edac_encoder
    import edac_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int C = CHK_W
) (
    input  logic [W-1:0] word,
    output logic [C-1:0] chk
);

    for (genvar k = 0; k < C; k++) begin : g_row
        localparam logic [W-1:0] MASK = row_mask(k);
        // Parity of the masked word bits for check bit k.
        assign chk[k] = ^(word & MASK);
    end

endmodule

// File: rtl/edac_decoder.sv
// Module: syndrome decoder and corrector. Assumes the check bits were
// made by edac_encoder. It flips the one word bit whose column matches
// the syndrome. A weight-1 syndrome is a check-bit error and is
// correctable. Any other nonzero syndrome is uncorrectable and leaves the
// word unchanged.
module edac_decoder
    import edac_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int C = CHK_W
) (
    input  logic [W-1:0] word_in,
    input  logic [C-1:0] chk_in,
    input  logic         corr_en,
    output logic [W-1:0] word_out,
    output logic         single_err,
    output logic         multi_err
);

    logic [C-1:0] chk_calc;
    logic [C-1:0] syndrome;
    logic [W-1:0] hit;

    edac_encoder #(.W(W), .C(C)) u_recalc (
        .word (word_in),
        .chk  (chk_calc)
    );

    // Difference between recomputed and stored check bits.
    assign syndrome = chk_calc ^ chk_in;

    for (genvar i = 0; i < W; i++) begin : g_col
        localparam logic [C-1:0] COL = word_col(i);
        // Syndrome points at word bit i.
        assign hit[i] = (syndrome == COL);
    end

    // Classify the syndrome and repair the word when enabled.
    always_comb begin
        single_err = (syndrome != '0) && ((|hit) || $onehot(syndrome));
        multi_err  = (syndrome != '0) && !single_err;
        word_out   = corr_en ? (word_in ^ hit) : word_in;
    end

    // A zero syndrome must never alter the word (R2).
    always_comb begin
        if (syndrome == '0) begin
            p_zero_syn_clean_r2: assert (word_out == word_in && !single_err && !multi_err)
                else $error("zero syndrome altered word");
        end
    end

endmodule

// File: rtl/edac_bus_ctrl.sv
// Module: select gating, driver direction and flag policy. Assumes the
// decode results are valid only during a read. The external error is
// merged after the flag-enable gate, so it always reaches ncerr_n.
module edac_bus_ctrl (
    input  logic sel_a_n,
    input  logic sel_b_n,
    input  logic sel_c,
    input  logic rd_wr_n,
    input  logic flag_en,
    input  logic ext_err_n,
    input  logic single_err,
    input  logic multi_err,
    output logic pd_oe,
    output logic md_oe,
    output logic cerr_n,
    output logic ncerr_n
);

    logic selected;
    logic rd_report;

    // Decode the three-way select and direction into driver enables and flags.
    always_comb begin
        selected  = !sel_a_n && !sel_b_n && sel_c;
        pd_oe     = selected && rd_wr_n;
        md_oe     = selected && !rd_wr_n;
        rd_report = pd_oe && flag_en;
        cerr_n    = !(rd_report && single_err);
        ncerr_n   = !((rd_report && multi_err) || !ext_err_n);
    end

    // Driver, masking and merge invariants (R7, R8, R9).
    always_comb begin
        p_oe_excl_r9: assert (!(pd_oe && md_oe))
            else $error("both drivers enabled");
        if (!flag_en) begin
            p_flag_mask_r7: assert (cerr_n && (ncerr_n == ext_err_n))
                else $error("flags not masked");
        end
        if (!ext_err_n) begin
            p_ext_merge_r8: assert (!ncerr_n)
                else $error("external error lost");
        end
    end

endmodule

// File: rtl/edac_feedthrough.sv
// Module: top of the feedthrough corrector. Routes processor data to
// memory with generated check bits on writes. On reads it routes checked
// and corrected memory data to the processor. Purely combinational. Each
// bus is split into in, out and enable ports.
module edac_feedthrough
    import edac_pkg::*;
(
    input  logic [WORD_W-1:0] pd_in,
    output logic [WORD_W-1:0] pd_out,
    output logic              pd_oe,
    input  logic [WORD_W-1:0] md_in,
    output logic [WORD_W-1:0] md_out,
    input  logic [CHK_W-1:0]  cb_in,
    output logic [CHK_W-1:0]  cb_out,
    output logic              md_oe,
    input  logic              rd_wr_n,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              sel_c,
    input  logic              corr_en,
    input  logic              flag_en,
    input  logic              ext_err_n,
    output logic              cerr_n,
    output logic              ncerr_n
);

    logic single_err;
    logic multi_err;

    edac_encoder #(.W(WORD_W), .C(CHK_W)) u_gen (
        .word (pd_in),
        .chk  (cb_out)
    );

    edac_decoder #(.W(WORD_W), .C(CHK_W)) u_dec (
        .word_in    (md_in),
        .chk_in     (cb_in),
        .corr_en    (corr_en),
        .word_out   (pd_out),
        .single_err (single_err),
        .multi_err  (multi_err)
    );

    edac_bus_ctrl u_ctl (
        .sel_a_n    (sel_a_n),
        .sel_b_n    (sel_b_n),
        .sel_c      (sel_c),
        .rd_wr_n    (rd_wr_n),
        .flag_en    (flag_en),
        .ext_err_n  (ext_err_n),
        .single_err (single_err),
        .multi_err  (multi_err),
        .pd_oe      (pd_oe),
        .md_oe      (md_oe),
        .cerr_n     (cerr_n),
        .ncerr_n    (ncerr_n)
    );

    // Write path: processor word feeds memory unchanged.
    assign md_out = pd_in;

    // Cross-module invariants (R1, R5, R6).
    always_comb begin
        if (!corr_en) begin
            p_bypass_raw_r6: assert (pd_out == md_in)
                else $error("bypass altered data");
        end
        if (md_oe) begin
            p_write_mirror_r1: assert (md_out == pd_in && !pd_oe)
                else $error("write path mismatch");
        end
        if (ext_err_n) begin
            p_flag_excl_r5: assert (cerr_n || ncerr_n)
                else $error("both flags asserted");
        end
    end

endmodule

// File: tb/tb_edac_feedthrough.sv
module tb_edac_feedthrough;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [16:0] pd_in, pd_out, md_in, md_out;
    logic [5:0]  cb_in, cb_out;
    logic pd_oe, md_oe, rd_wr_n, sel_a_n, sel_b_n, sel_c;
    logic corr_en, flag_en, ext_err_n, cerr_n, ncerr_n;

    edac_feedthrough dut (
        .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .md_in(md_in), .md_out(md_out), .cb_in(cb_in), .cb_out(cb_out),
        .md_oe(md_oe), .rd_wr_n(rd_wr_n), .sel_a_n(sel_a_n),
        .sel_b_n(sel_b_n), .sel_c(sel_c), .corr_en(corr_en),
        .flag_en(flag_en), .ext_err_n(ext_err_n),
        .cerr_n(cerr_n), .ncerr_n(ncerr_n)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Column of word bit idx per R11: idx-th weight-3 value, ascending.
    function automatic logic [5:0] tb_col(input int idx);
        int seen = 0;
        logic [5:0] r = '0;
        for (int v = 0; v < 64; v++) begin
            if ($countones(v[5:0]) == 3) begin
                if (seen == idx) r = v[5:0];
                seen++;
            end
        end
        return r;
    endfunction

    function automatic logic [5:0] tb_enc(input logic [16:0] w);
        logic [5:0] c = '0;
        for (int i = 0; i < 17; i++) begin
            if (w[i]) c = c ^ tb_col(i);
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [16:0] data;
        logic [22:0] emask;   // bits 16:0 word, bits 22:17 check bits
        logic        corr;
        logic        flg;
        logic        exp_c_n;
        logic        exp_nc_n;
        logic        exp_fixed; // 1: pd_out == data, 0: pd_out == raw md_in
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{17'h01234, 23'h000000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 clean
        '{17'h1ABCD, 23'h000001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R3 bit 0
        '{17'h0FFFF, 23'h010000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R3 parity bit
        '{17'h15555, 23'h080000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 check bit 2
        '{17'h0A5A5, 23'h000208, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 two word bits
        '{17'h00000, 23'h060000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R5 two check bits
        '{17'h1F00F, 23'h000020, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R6 bypass
        '{17'h13579, 23'h000080, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R7 single masked
        '{17'h02468, 23'h000804, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R7 double masked
        '{17'h1FFFF, 23'h000000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}  // R2 clean
    };

    task automatic drive(input logic rw, input logic a, input logic b, input logic c);
        @(posedge clk);
        rd_wr_n = rw; sel_a_n = a; sel_b_n = b; sel_c = c;
    endtask

    initial begin
        pd_in = '0; md_in = '0; cb_in = '0;
        rd_wr_n = 1'b1; sel_a_n = 1'b1; sel_b_n = 1'b1; sel_c = 1'b0;
        corr_en = 1'b1; flag_en = 1'b1; ext_err_n = 1'b1;
        @(negedge clk);
        // Idle state (R9).
        check("R9 idle pd_oe", {31'd0, pd_oe}, 32'd0);
        check("R9 idle md_oe", {31'd0, md_oe}, 32'd0);
        check("R9 idle flags", {30'd0, cerr_n, ncerr_n}, 32'd3);

        // Vector table: read cycles (R2..R7).
        for (int v = 0; v < NV; v++) begin
            drive(1'b1, 1'b0, 1'b0, 1'b1);
            corr_en = VECS[v].corr;
            flag_en = VECS[v].flg;
            md_in = VECS[v].data ^ VECS[v].emask[16:0];
            cb_in = tb_enc(VECS[v].data) ^ VECS[v].emask[22:17];
            @(negedge clk);
            check($sformatf("R2 oe vec%0d", v), {30'd0, pd_oe, md_oe}, 32'd2);
            check($sformatf("R3 data vec%0d", v), {15'd0, pd_out},
                  {15'd0, VECS[v].exp_fixed ? VECS[v].data : md_in});
            check($sformatf("R5 flags vec%0d", v), {30'd0, cerr_n, ncerr_n},
                  {30'd0, VECS[v].exp_c_n, VECS[v].exp_nc_n});
        end
        corr_en = 1'b1; flag_en = 1'b1;

        // R11: explicit code values.
        check("R11 col bit0", {26'd0, tb_enc(17'h00001)}, 32'h07);
        check("R11 col bit16", {26'd0, tb_enc(17'h10000)}, 32'h31);

        // R1 write cycles; R11 checked on cb_out against fixed values.
        drive(1'b0, 1'b0, 1'b0, 1'b1);
        pd_in = 17'h00001;
        @(negedge clk);
        check("R11 cb_out bit0", {26'd0, cb_out}, 32'h07);
        check("R1 oe write", {30'd0, pd_oe, md_oe}, 32'd1);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            pd_in = 17'h0B3C1 ^ (17'h1248F << k);
            @(negedge clk);
            check("R1 md_out", {15'd0, md_out}, {15'd0, pd_in});
            check("R1 cb_out", {26'd0, cb_out}, {26'd0, tb_enc(pd_in)});
        end

        // R10: corrupt memory during a write gives no flags.
        md_in = 17'h00003; cb_in = 6'h00;
        @(negedge clk);
        check("R10 write flags", {30'd0, cerr_n, ncerr_n}, 32'd3);

        // R9: each single deselect pattern during an erroneous read.
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check("R9 sel_a_n high", {28'd0, pd_oe, md_oe, cerr_n, ncerr_n}, 32'd3);
        drive(1'b1, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        check("R9 sel_b_n high", {28'd0, pd_oe, md_oe, cerr_n, ncerr_n}, 32'd3);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 sel_c low", {28'd0, pd_oe, md_oe, cerr_n, ncerr_n}, 32'd3);

        // R8: external error while deselected, in a write, and with flags off.
        ext_err_n = 1'b0;
        @(negedge clk);
        check("R8 deselected", {31'd0, ncerr_n}, 32'd0);
        drive(1'b0, 1'b0, 1'b0, 1'b1);
        flag_en = 1'b0;
        @(negedge clk);
        check("R8 write flag off", {30'd0, cerr_n, ncerr_n}, 32'd2);
        ext_err_n = 1'b1;
        @(negedge clk);
        check("R8 released", {31'd0, ncerr_n}, 32'd1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule